// File: doc/BRIEF.md
# Unsigned Adder-Subtractor with Magnitude Correction

This block is a purely combinational unit that adds or subtracts two unsigned N-bit operands. A single mode pin chooses the operation. In add mode the block returns the low N bits of the sum and the carry out of the top bit.

In subtract mode both operations share one ripple adder. Each subtrahend bit passes through an XOR with the mode pin, and the mode pin also feeds the carry-in, so the adder forms X + ~Y + 1. When the top bit produces a carry, the raw word is already X − Y. When it produces none, Y was larger and the raw word equals 2^N + X − Y. A selective complementer then inverts that word and adds one, and the block raises a negative flag. The output is therefore always a magnitude plus a sign.

A second, independent subtractor is chained from one-bit borrow cells. It feeds its own complementer and drives a cross-check magnitude and sign pair on separate outputs. An integrating block can compare the two results, or use either one.

The unit has no clock and no handshake, because data is valid in the same cycle the operands are applied. The bench samples it on a 50 MHz clock only to pace its scoreboard.

Top module: `usub_addsub_unit`

## Requirements
- R1: With sub_mode_i = 0, result_o equals (x_i + y_i) mod 2^N and carry_o equals bit N of the full sum.
- R2: With sub_mode_i = 0, negative_o is 0 for every operand pair.
- R3: With sub_mode_i = 1 and x_i > y_i, result_o equals x_i − y_i, negative_o is 0 and carry_o is 1.
- R4: With sub_mode_i = 1 and y_i > x_i, result_o equals y_i − x_i, negative_o is 1 and carry_o is 0. In this case the raw adder word is complemented by inverting it and adding one.
- R5: With sub_mode_i = 1 and x_i = y_i, result_o is 0, negative_o is 0 and carry_o is 1.
- R6: Each borrow cell, indexed by {minuend, subtrahend, borrow-in} as a 3-bit number, gives difference 1 for indices 1, 2, 4 and 7, and borrow-out 1 for indices 1, 2, 3 and 7.
- R7: In either mode, alt_mag_o equals |x_i − y_i| and alt_neg_o equals 1 exactly when y_i > x_i. With sub_mode_i = 1 these outputs match result_o and negative_o.
- R8: For N = 6, 15 − 20 gives result_o = 6'b000101 with negative_o = 1 and carry_o = 0.
- R9: The width parameter N defaults to 8 and works for any N ≥ 2. For N = 10, 84 − 67 gives result_o = 17 with negative_o = 0 and carry_o = 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| x_i | input | N | First operand (minuend in subtract mode) |
| y_i | input | N | Second operand (subtrahend in subtract mode) |
| sub_mode_i | input | 1 | 0 = add, 1 = subtract |
| result_o | output | N | Sum, or magnitude of the difference |
| carry_o | output | 1 | End carry of the shared adder |
| negative_o | output | 1 | Difference is negative (subtract mode only) |
| alt_mag_o | output | N | Magnitude from the borrow-cell subtractor |
| alt_neg_o | output | 1 | Sign from the borrow-cell subtractor |

## Verification
Some properties are checked whenever the inputs change:
- each borrow cell obeys its arithmetic identity;
- every enabled complementer output sums with its input to zero;
- the add path matches an N+1-bit sum and never reports negative;
- in subtract mode, the shared-adder path and the borrow-cell path agree on magnitude and sign.

Only the bench's scenarios show that the results are numerically right. The scoreboard sweeps every operand pair in both modes at N = 6 against an integer reference. It also covers the equal-operand and carry-boundary cases, and the two worked examples at widths 6 and 10.

// File: rtl/usub_pkg.sv
package usub_pkg;
  typedef enum logic {
    OP_ADD = 1'b0,
    OP_SUB = 1'b1
  } op_e;

  // Truth maps for the one-bit borrow cell, indexed by {minuend, subtrahend, borrow_in}
  localparam logic [7:0] CELL_DIFF_MAP = 8'b1001_0110;
  localparam logic [7:0] CELL_BOUT_MAP = 8'b1000_1110;
endpackage

// File: rtl/usub_borrow_cell.sv
module usub_borrow_cell
  import usub_pkg::*;
(
  input  logic minu_i,
  input  logic subt_i,
  input  logic bin_i,
  output logic diff_o,
  output logic bout_o
);
  logic [2:0] sel;

  always_comb begin
    sel    = {minu_i, subt_i, bin_i};
    diff_o = CELL_DIFF_MAP[sel];
    bout_o = CELL_BOUT_MAP[sel];
  end

  // R6: minuend - subtrahend - borrow_in == diff - 2*borrow_out
  always_comb begin
    p_cell_arith_r6: assert ((int'(minu_i) - int'(subt_i) - int'(bin_i))
                             == (int'(diff_o) - 2 * int'(bout_o)));
  end
endmodule

// File: rtl/usub_borrow_chain.sv
module usub_borrow_chain #(
  parameter int W = 8
) (
  input  logic [W-1:0] minu_i,
  input  logic [W-1:0] subt_i,
  output logic [W-1:0] diff_o,
  output logic         borrow_o
);
  logic [W:0] brw;

  assign brw[0] = 1'b0;

  for (genvar i = 0; i < W; i++) begin : g_cell
    usub_borrow_cell u_cell (
      .minu_i (minu_i[i]),
      .subt_i (subt_i[i]),
      .bin_i  (brw[i]),
      .diff_o (diff_o[i]),
      .bout_o (brw[i+1])
    );
  end

  assign borrow_o = brw[W];

  // R7: the chain forms the wrapped difference and a borrow when subt > minu
  always_comb begin
    p_chain_diff_r7: assert ({borrow_o, diff_o} == ({1'b0, minu_i} - {1'b0, subt_i}));
  end
endmodule

// File: rtl/usub_xor_adder.sv
module usub_xor_adder #(
  parameter int W = 8
) (
  input  logic [W-1:0] a_i,
  input  logic [W-1:0] b_i,
  input  logic         sub_i,
  output logic [W-1:0] sum_o,
  output logic         cout_o
);
  logic [W:0]   cy;
  logic [W-1:0] b_eff;

  assign cy[0] = sub_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign b_eff[i]  = b_i[i] ^ sub_i;
    assign sum_o[i]  = a_i[i] ^ b_eff[i] ^ cy[i];
    assign cy[i+1]   = (a_i[i] & b_eff[i]) | (a_i[i] & cy[i]) | (b_eff[i] & cy[i]);
  end

  assign cout_o = cy[W];
endmodule

// File: rtl/usub_negator.sv
module usub_negator #(
  parameter int W = 8
) (
  input  logic [W-1:0] val_i,
  input  logic         en_i,
  output logic [W-1:0] val_o
);
  logic [W-1:0] inv;
  logic [W-1:0] cy;

  assign cy[0] = en_i;

  for (genvar i = 0; i < W; i++) begin : g_bit
    assign inv[i]   = val_i[i] ^ en_i;
    assign val_o[i] = inv[i] ^ cy[i];
    if (i < W - 1) begin : g_carry
      assign cy[i+1] = inv[i] & cy[i];
    end
  end

  // R4: an enabled complement cancels its input modulo 2^W; disabled passes through
  always_comb begin
    if (en_i) p_negate_sum_zero_r4: assert (W'(val_o + val_i) == '0);
    else      p_negate_pass_r4:     assert (val_o == val_i);
  end
endmodule

// File: rtl/usub_addsub_unit.sv
module usub_addsub_unit
  import usub_pkg::*;
#(
  parameter int N = 8
) (
  input  logic [N-1:0] x_i,
  input  logic [N-1:0] y_i,
  input  logic         sub_mode_i,
  output logic [N-1:0] result_o,
  output logic         carry_o,
  output logic         negative_o,
  output logic [N-1:0] alt_mag_o,
  output logic         alt_neg_o
);
  localparam int SUM_W = N + 1;

  op_e          op;
  logic [N-1:0] raw_sum;
  logic         raw_cout;
  logic         fix_en;
  logic [N-1:0] fixed_val;
  logic [N-1:0] chain_diff;
  logic         chain_borrow;

  assign op = op_e'(sub_mode_i);

  usub_xor_adder #(.W(N)) u_adder (
    .a_i    (x_i),
    .b_i    (y_i),
    .sub_i  (sub_mode_i),
    .sum_o  (raw_sum),
    .cout_o (raw_cout)
  );

  assign fix_en = (op == OP_SUB) && !raw_cout;

  usub_negator #(.W(N)) u_fix (
    .val_i (raw_sum),
    .en_i  (fix_en),
    .val_o (fixed_val)
  );

  for (genvar i = 0; i < N; i++) begin : g_mux
    assign result_o[i] = (op == OP_SUB) ? fixed_val[i] : raw_sum[i];
  end

  assign carry_o    = raw_cout;
  assign negative_o = fix_en;

  usub_borrow_chain #(.W(N)) u_chain (
    .minu_i   (x_i),
    .subt_i   (y_i),
    .diff_o   (chain_diff),
    .borrow_o (chain_borrow)
  );

  usub_negator #(.W(N)) u_alt_fix (
    .val_i (chain_diff),
    .en_i  (chain_borrow),
    .val_o (alt_mag_o)
  );

  assign alt_neg_o = chain_borrow;

  always_comb begin
    if (op == OP_ADD) begin
      p_add_sum_r1:      assert ({carry_o, result_o} == (SUM_W'(x_i) + SUM_W'(y_i)));
      p_add_positive_r2: assert (!negative_o);
    end else begin
      p_paths_agree_r7:  assert (result_o == alt_mag_o && negative_o == alt_neg_o);
      p_sign_carry_r3:   assert (negative_o != carry_o);
      if (x_i == y_i) begin
        p_zero_positive_r5: assert (result_o == '0 && !negative_o);
      end
    end
  end
endmodule

// File: tb/usub_addsub_unit_tb_top.sv
module usub_addsub_unit_tb_top;
  localparam int W   = 6;
  localparam int W10 = 10;
  localparam int WATCHDOG = 50000;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n;

  logic [W-1:0] x, y, res, amag;
  logic         sub, cout, neg, aneg;

  logic [W10-1:0] x10, y10, res10, amag10;
  logic           sub10, cout10, neg10, aneg10;

  usub_addsub_unit #(.N(W)) dut_i (
    .x_i(x), .y_i(y), .sub_mode_i(sub),
    .result_o(res), .carry_o(cout), .negative_o(neg),
    .alt_mag_o(amag), .alt_neg_o(aneg)
  );

  usub_addsub_unit #(.N(W10)) dut10_i (
    .x_i(x10), .y_i(y10), .sub_mode_i(sub10),
    .result_o(res10), .carry_o(cout10), .negative_o(neg10),
    .alt_mag_o(amag10), .alt_neg_o(aneg10)
  );

  typedef struct {
    logic         sub;
    logic [W-1:0] x, y, res;
    logic         cout, neg;
    logic [W-1:0] amag;
    logic         aneg;
  } exp_t;

  exp_t sb_q[$];
  int   checks = 0;
  int   errors = 0;
  int   cyc    = 0;
  bit   done   = 1'b0;

  task automatic chk(input string tag, input string what, input int act, input int expv);
    checks++;
    if (act != expv) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, expv);
    end
  endtask

  // Driver: compute reference from the requirements and push it
  task automatic drive(input bit s, input int a, input int b);
    exp_t e;
    int   full;
    e.sub = s;
    e.x   = W'(a);
    e.y   = W'(b);
    if (!s) begin
      full   = a + b;
      e.res  = W'(full);
      e.cout = (full >= (1 << W));
      e.neg  = 1'b0;
    end else if (a >= b) begin
      e.res = W'(a - b); e.cout = 1'b1; e.neg = 1'b0;
    end else begin
      e.res = W'(b - a); e.cout = 1'b0; e.neg = 1'b1;
    end
    e.amag = (a >= b) ? W'(a - b) : W'(b - a);
    e.aneg = (a < b);
    @(posedge clk);
    #1;
    x = e.x; y = e.y; sub = e.sub;
    sb_q.push_back(e);
  endtask

  // Monitor: pop and compare mid-cycle
  always @(negedge clk) begin
    exp_t  e;
    string tag;
    if (rst_n && sb_q.size() > 0) begin
      e = sb_q.pop_front();
      if (!e.sub)             tag = "R1";
      else if (e.x == e.y)    tag = "R5";
      else if (e.neg)         tag = "R4";
      else                    tag = "R3";
      chk(tag, "result", int'(res), int'(e.res));
      chk(tag, "carry",  int'(cout), int'(e.cout));
      if (!e.sub) chk("R2", "negative", int'(neg), 0);
      else        chk(tag,  "negative", int'(neg), int'(e.neg));
      // R6 cells are covered through the exhaustive chain sweep below
      chk("R7", "alt_mag", int'(amag), int'(e.amag));
      chk("R7", "alt_neg", int'(aneg), int'(e.aneg));
    end
  end

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > WATCHDOG && !done) begin
      done = 1'b1;
      checks++;
      errors++;
      $display("FAIL R1 watchdog actual=%0d expected<%0d cycles", cyc, WATCHDOG);
      summary();
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    x = '0; y = '0; sub = 1'b0;
    x10 = '0; y10 = '0; sub10 = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    // reset state: zero operands in add mode
    chk("R1", "reset result", int'(res), 0);
    chk("R2", "reset negative", int'(neg), 0);
    rst_n = 1'b1;

    // boundary patterns
    drive(1'b0, 63, 1);          // R1 carry out, zero sum
    drive(1'b0, 63, 63);         // R1 max operands
    drive(1'b1, 0, 63);          // R4 largest negative
    drive(1'b1, 63, 0);          // R3 largest positive
    drive(1'b1, 42, 42);         // R5 equal operands
    drive(1'b1, 0, 0);           // R5 zero
    drive(1'b1, 7, 15);          // R4 small negative

    // exhaustive sweep, both modes (R1..R7)
    for (int m = 0; m < 2; m++)
      for (int a = 0; a < (1 << W); a++)
        for (int b = 0; b < (1 << W); b++)
          drive(m[0], a, b);

    wait (sb_q.size() == 0);
    @(posedge clk);

    // R8: worked example 15 - 20 at N = 6
    #1; x = 6'd15; y = 6'd20; sub = 1'b1;
    @(negedge clk);
    chk("R8", "result", int'(res), 5);
    chk("R8", "negative", int'(neg), 1);
    chk("R8", "carry", int'(cout), 0);

    // R9: second width, 84 - 67 and a wrapping add
    @(posedge clk);
    #1; x10 = 10'd84; y10 = 10'd67; sub10 = 1'b1;
    @(negedge clk);
    chk("R9", "result", int'(res10), 17);
    chk("R9", "negative", int'(neg10), 0);
    chk("R9", "carry", int'(cout10), 1);
    @(posedge clk);
    #1; x10 = 10'd67; y10 = 10'd84; sub10 = 1'b1;
    @(negedge clk);
    chk("R9", "neg result", int'(res10), 17);
    chk("R9", "neg flag", int'(neg10), 1);
    chk("R9", "alt_mag", int'(amag10), 17);
    @(posedge clk);
    #1; x10 = 10'd1000; y10 = 10'd100; sub10 = 1'b0;
    @(negedge clk);
    chk("R9", "add result", int'(res10), 76);
    chk("R9", "add carry", int'(cout10), 1);
    chk("R9", "add negative", int'(neg10), 0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule